// File: doc/BRIEF.md
# Five-Subinterval Modulation Period Sequencer

This block times one switching period of a modulator that drives both sides of a converter at once. Each side runs a three-vector pattern: the null vector first, then the active vector with the larger duty, then the active vector with the smaller duty. The two sides switch at different instants, so their edges merge into four boundary times. These four times cut the period into five subintervals.

A host writes the four boundary counts, the period length, and a payload for each of the five subintervals. A payload holds an input-side vector, an output-side vector and a capacitor number. All of these writes go to shadow registers, which are copied to the working set only when a new period begins. A free-running counter on the system clock walks through the period. At every count the block presents the current subinterval code together with that subinterval's payload as a single 19-bit word. It raises one strobe whenever the subinterval changes and another at the start of each period.

At a 25 MHz clock, one count is 40 ns, so a 50 kHz period is 500 counts. That is the reset value of the length register. The block does not compute duty cycles, does not turn vectors into switch states, and does not time the gates.

Top module: `seq5_period_sequencer`

## Requirements
- R1: The period length register resets to 500. A period lasts L clock cycles, where L is the active length. `start_pulse` is high in the first cycle of every period, including the first cycle after reset, and low otherwise.
- R2: The subinterval code runs from 0 to 4. At count c from the start of a period, the code equals the number of active boundaries that are less than or equal to c, compared as unsigned values. Boundary slots 0 to 3 are written through `edge_sel`.
- R3: `seq_word` is {code in bits 18:16, payload in bits 15:0}. The payload is the active value written for the slot whose index equals the code. Inside the payload, the input vector is in bits 15:10, the output vector in bits 9:4 and the capacitor number in bits 3:0.
- R4: When two boundaries are equal, the subinterval between them has zero length. Its code never appears on `seq_word` and it produces no strobe of its own. A boundary equal to L means that the later subintervals are not reached in that period.
- R5: `edge_pulse` is high in the first cycle of every period. It is also high in every cycle whose code differs from the code of the previous cycle, and low in all other cycles.
- R6: Boundary, payload and length writes land in shadow registers. The active values change only at a period start. A value written in any cycle other than the last cycle of a period is in force from the next period start.
- R7: A value written in the last cycle of a period misses that copy. It takes effect only at the start of the period after next.
- R8: After reset, all boundaries and payloads are zero, so `seq_word` shows code 4 with a zero payload.
- R9: An active period length of 0 behaves as a length of 1: every cycle starts a new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one count per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_we | input | 1 | Write strobe for one boundary shadow |
| edge_sel | input | 2 | Boundary slot index, 0 to 3 |
| edge_val | input | CNT_W (12) | Boundary count value |
| slot_we | input | 1 | Write strobe for one subinterval payload shadow |
| slot_sel | input | 3 | Payload slot index, 0 to 4 (5 to 7 ignored) |
| slot_val | input | PAY_W (16) | Payload {input vector, output vector, capacitor} |
| len_we | input | 1 | Write strobe for the period length shadow |
| len_val | input | CNT_W (12) | Period length in clock cycles |
| seq_word | output | 19 | {subinterval code, active payload} |
| edge_pulse | output | 1 | One-cycle strobe on each subinterval change |
| start_pulse | output | 1 | One-cycle strobe at each period start |

## Verification
The assertions check the following on every cycle:
- the code stays in range and never falls back inside a period;
- every code change carries an edge strobe, and no edge strobe appears without a change or a period start;
- the word holds steady between strobes;
- the active length moves only at a period start.

Only the bench scenarios can show the rest. These are the exact code at each count for every ordered set of boundaries on a short period, the reset-time length of 500 cycles, the late-write miss of one period, and the collapse of a zero length to a single-cycle period.

// File: rtl/seq5_pkg.sv
package seq5_pkg;
   localparam int NUM_SUB    = 5;
   localparam int NUM_EDGE   = 4;
   localparam int CODE_W     = 3;
   localparam int EDGE_SEL_W = 2;

   typedef logic [CODE_W-1:0] sub_code_t;

   // Number of boundaries already passed by the counter
   function automatic sub_code_t tally(input logic [NUM_EDGE-1:0] hits);
      sub_code_t n;
      n = '0;
      for (int k = 0; k < NUM_EDGE; k++) begin
         n = n + sub_code_t'(hits[k]);
      end
      return n;
   endfunction
endpackage

// File: rtl/seq5_shadow_bank.sv
module seq5_shadow_bank
   import seq5_pkg::*;
#(
   parameter int CNT_W      = 12,
   parameter int PAY_W      = 16,
   parameter int PERIOD_RST = 500
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             edge_we,
   input  logic [EDGE_SEL_W-1:0]            edge_sel,
   input  logic [CNT_W-1:0]                 edge_val,
   input  logic                             slot_we,
   input  logic [CODE_W-1:0]                slot_sel,
   input  logic [PAY_W-1:0]                 slot_val,
   input  logic                             len_we,
   input  logic [CNT_W-1:0]                 len_val,
   input  logic                             commit,
   output logic [NUM_EDGE-1:0][CNT_W-1:0]   act_edge,
   output logic [NUM_SUB-1:0][PAY_W-1:0]    act_slot,
   output logic [CNT_W-1:0]                 act_len
);

   // Boundary registers: shadow written by host, active copied at period start
   for (genvar g = 0; g < NUM_EDGE; g++) begin : g_edge
      logic [CNT_W-1:0] shd_q;
      logic [CNT_W-1:0] act_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shd_q <= '0;
            act_q <= '0;
         end else begin
            if (edge_we && (edge_sel == EDGE_SEL_W'(g))) shd_q <= edge_val;
            if (commit) act_q <= shd_q;
         end
      end
      assign act_edge[g] = act_q;
   end

   // Subinterval payload registers
   for (genvar g = 0; g < NUM_SUB; g++) begin : g_slot
      logic [PAY_W-1:0] shd_q;
      logic [PAY_W-1:0] act_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shd_q <= '0;
            act_q <= '0;
         end else begin
            if (slot_we && (slot_sel == CODE_W'(g))) shd_q <= slot_val;
            if (commit) act_q <= shd_q;
         end
      end
      assign act_slot[g] = act_q;
   end

   // Period length
   logic [CNT_W-1:0] len_shd_q;
   logic [CNT_W-1:0] len_act_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_shd_q <= CNT_W'(PERIOD_RST);
         len_act_q <= CNT_W'(PERIOD_RST);
      end else begin
         if (len_we) len_shd_q <= len_val;
         if (commit) len_act_q <= len_shd_q;
      end
   end
   assign act_len = len_act_q;

endmodule

// File: rtl/seq5_timer.sv
module seq5_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] len,
   output logic [CNT_W-1:0] cnt,
   output logic             period_last,
   output logic             period_first
);

   logic [CNT_W:0] cnt_inc;

   // Compare one bit wider so that a length of 0 yields a one-cycle period
   assign cnt_inc      = {1'b0, cnt} + (CNT_W+1)'(1);
   assign period_last  = cnt_inc >= {1'b0, len};
   assign period_first = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (period_last) cnt <= '0;
      else                  cnt <= cnt_inc[CNT_W-1:0];
   end

endmodule

// File: rtl/seq5_locate.sv
module seq5_locate
   import seq5_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic [CNT_W-1:0]               cnt,
   input  logic [NUM_EDGE-1:0][CNT_W-1:0] edges,
   output sub_code_t                      code
);

   logic [NUM_EDGE-1:0] hits;

   // One comparator per boundary; the code is how many have been passed
   for (genvar g = 0; g < NUM_EDGE; g++) begin : g_cmp
      assign hits[g] = (cnt >= edges[g]);
   end

   assign code = tally(hits);

endmodule

// File: rtl/seq5_period_sequencer.sv
module seq5_period_sequencer
   import seq5_pkg::*;
#(
   parameter  int CNT_W      = 12,
   parameter  int IVEC_W     = 6,
   parameter  int OVEC_W     = 6,
   parameter  int CAP_W      = 4,
   parameter  int PERIOD_RST = 500,
   localparam int PAY_W      = IVEC_W + OVEC_W + CAP_W,
   localparam int WORD_W     = CODE_W + PAY_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  edge_we,
   input  logic [EDGE_SEL_W-1:0] edge_sel,
   input  logic [CNT_W-1:0]      edge_val,
   input  logic                  slot_we,
   input  logic [CODE_W-1:0]     slot_sel,
   input  logic [PAY_W-1:0]      slot_val,
   input  logic                  len_we,
   input  logic [CNT_W-1:0]      len_val,
   output logic [WORD_W-1:0]     seq_word,
   output logic                  edge_pulse,
   output logic                  start_pulse
);

   // Elaboration-time parameter checks
   if (CNT_W < 2 || CNT_W > 30) begin : g_bad_cnt
      $error("seq5_period_sequencer: CNT_W out of range");
   end
   if (IVEC_W < 1 || OVEC_W < 1 || CAP_W < 1) begin : g_bad_pay
      $error("seq5_period_sequencer: payload field widths must be positive");
   end
   if (PERIOD_RST < 0 || PERIOD_RST >= (1 << CNT_W)) begin : g_bad_rst
      $error("seq5_period_sequencer: PERIOD_RST does not fit CNT_W");
   end

   logic [NUM_EDGE-1:0][CNT_W-1:0] act_edge;
   logic [NUM_SUB-1:0][PAY_W-1:0]  act_slot;
   logic [CNT_W-1:0]               act_len;
   logic [CNT_W-1:0]               cnt;
   logic                           last_cyc;
   logic                           first_cyc;
   sub_code_t                      code;
   sub_code_t                      code_q;
   logic [PAY_W-1:0]               pay;

   seq5_shadow_bank #(
      .CNT_W      (CNT_W),
      .PAY_W      (PAY_W),
      .PERIOD_RST (PERIOD_RST)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .edge_we  (edge_we),
      .edge_sel (edge_sel),
      .edge_val (edge_val),
      .slot_we  (slot_we),
      .slot_sel (slot_sel),
      .slot_val (slot_val),
      .len_we   (len_we),
      .len_val  (len_val),
      .commit   (last_cyc),
      .act_edge (act_edge),
      .act_slot (act_slot),
      .act_len  (act_len)
   );

   seq5_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .len          (act_len),
      .cnt          (cnt),
      .period_last  (last_cyc),
      .period_first (first_cyc)
   );

   seq5_locate #(
      .CNT_W (CNT_W)
   ) u_locate (
      .cnt   (cnt),
      .edges (act_edge),
      .code  (code)
   );

   // Previous code, used to detect subinterval changes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= '0;
      else        code_q <= code;
   end

   // Payload selection for the present subinterval
   always_comb begin
      pay = '0;
      for (int k = 0; k < NUM_SUB; k++) begin
         if (code == CODE_W'(k)) pay = act_slot[k];
      end
   end

   assign seq_word    = {code, pay};
   assign start_pulse = first_cyc;
   assign edge_pulse  = first_cyc | (code != code_q);

endmodule

// File: rtl/seq5_checker.sv
module seq5_checker
   import seq5_pkg::*;
#(
   parameter int CNT_W  = 12,
   parameter int WORD_W = 19
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WORD_W-1:0] seq_word,
   input logic              edge_pulse,
   input logic              start_pulse,
   input logic [CNT_W-1:0]  act_len
);

   sub_code_t code;
   assign code = seq_word[WORD_W-1 -: CODE_W];

   assert_code_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      code <= CODE_W'(NUM_SUB - 1));

   assert_code_rises_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !start_pulse |-> (code >= $past(code)));

   assert_start_marks_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> edge_pulse);

   assert_change_flagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (code != $past(code)) |-> edge_pulse);

   assert_no_spurious_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_pulse && (code == $past(code))) |-> !edge_pulse);

   assert_word_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_pulse |-> $stable(seq_word));

   assert_len_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !start_pulse |-> $stable(act_len));

endmodule

bind seq5_period_sequencer seq5_checker #(
   .CNT_W  (CNT_W),
   .WORD_W (WORD_W)
) u_seq5_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .seq_word    (seq_word),
   .edge_pulse  (edge_pulse),
   .start_pulse (start_pulse),
   .act_len     (act_len)
);

// File: tb/tb_seq5_period_sequencer.sv
module tb_seq5_period_sequencer;
   localparam int CNT_W = 12;
   localparam int PAY_W = 16;
   localparam int PLEN  = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              edge_we = 1'b0;
   logic [1:0]        edge_sel = '0;
   logic [CNT_W-1:0]  edge_val = '0;
   logic              slot_we = 1'b0;
   logic [2:0]        slot_sel = '0;
   logic [PAY_W-1:0]  slot_val = '0;
   logic              len_we = 1'b0;
   logic [CNT_W-1:0]  len_val = '0;
   logic [18:0]       seq_word;
   logic              edge_pulse;
   logic              start_pulse;

   int n_chk = 0;
   int n_bad = 0;
   int cur_b[4];
   int nxt_b[4];
   int cur_p[5];
   int nxt_p[5];
   int cur_per;
   int nxt_per;
   string pay_tag = "R3";
   string st_tag  = "R1";

   always #5 clk = ~clk;

   seq5_period_sequencer dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .edge_we     (edge_we),
      .edge_sel    (edge_sel),
      .edge_val    (edge_val),
      .slot_we     (slot_we),
      .slot_sel    (slot_sel),
      .slot_val    (slot_val),
      .len_we      (len_we),
      .len_val     (len_val),
      .seq_word    (seq_word),
      .edge_pulse  (edge_pulse),
      .start_pulse (start_pulse)
   );

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic int exp_code(input int c);
      int n = 0;
      for (int k = 0; k < 4; k++) if (cur_b[k] <= c) n++;
      return n;
   endfunction

   task automatic clear_wr();
      edge_we = 1'b0;
      slot_we = 1'b0;
      len_we  = 1'b0;
   endtask

   // Entered at the negedge of the first cycle of a period.
   task automatic run_period(input bit do_wr, input int late_s, input int late_v);
      int plen = (cur_per == 0) ? 1 : cur_per;
      bit odd = (cur_b[0] == cur_b[1]) || (cur_b[1] == cur_b[2]) ||
                (cur_b[2] == cur_b[3]) || (cur_b[3] >= plen);
      for (int c = 0; c < plen; c++) begin
         int ec = exp_code(c);
         int pc = (c == 0) ? -1 : exp_code(c - 1);
         chk(odd ? "R4" : "R2", int'(seq_word[18:16]), ec);
         chk(pay_tag, int'(seq_word[15:0]), cur_p[ec]);
         chk("R5", int'(edge_pulse), (c == 0 || ec != pc) ? 1 : 0);
         chk(st_tag, int'(start_pulse), (c == 0) ? 1 : 0);
         if (do_wr && c == plen - 1)
            chk("R6", int'(seq_word[15:0]), cur_p[ec]);
         clear_wr();
         if (do_wr) begin
            if (c < 4) begin
               edge_we = 1'b1; edge_sel = 2'(c); edge_val = CNT_W'(nxt_b[c]);
            end else if (c < 9) begin
               slot_we = 1'b1; slot_sel = 3'(c - 4); slot_val = PAY_W'(nxt_p[c - 4]);
            end else if (c == 9) begin
               len_we = 1'b1; len_val = CNT_W'(nxt_per);
            end
         end
         if (late_s >= 0 && c == plen - 1) begin
            slot_we = 1'b1; slot_sel = 3'(late_s); slot_val = PAY_W'(late_v);
         end
         @(negedge clk);
      end
      clear_wr();
      cur_b = nxt_b;
      cur_p = nxt_p;
      cur_per = nxt_per;
      if (late_s >= 0) nxt_p[late_s] = late_v;
   endtask

   initial begin
      int idx = 0;
      int n;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R8: reset state, before any clock edge after release
      chk("R8", int'(seq_word[18:16]), 4);
      chk("R8", int'(seq_word[15:0]), 0);
      chk("R1", int'(start_pulse), 1);
      // R1: reset length is 500; queue a length of 12 for the next period
      len_we = 1'b1; len_val = CNT_W'(PLEN);
      n = 0;
      do begin
         @(negedge clk);
         clear_wr();
         n++;
      end while (!start_pulse && n < 600);
      chk("R1", n, 500);

      for (int k = 0; k < 4; k++) begin cur_b[k] = 0; nxt_b[k] = 0; end
      for (int k = 0; k < 5; k++) begin cur_p[k] = 0; nxt_p[k] = 0; end
      cur_per = PLEN;
      nxt_per = PLEN;

      // R2 R3 R4 R5 R6: every non-decreasing boundary set on a 12-cycle period
      for (int b0 = 0; b0 <= PLEN; b0++)
         for (int b1 = b0; b1 <= PLEN; b1++)
            for (int b2 = b1; b2 <= PLEN; b2++)
               for (int b3 = b2; b3 <= PLEN; b3++) begin
                  nxt_b[0] = b0; nxt_b[1] = b1; nxt_b[2] = b2; nxt_b[3] = b3;
                  for (int s = 0; s < 5; s++) nxt_p[s] = (idx * 97 + s * 13 + 1) & 16'hFFFF;
                  idx++;
                  run_period(1'b1, -1, 0);
               end

      // R7: late write in the last cycle lands one period later
      for (int k = 0; k < 4; k++) nxt_b[k] = 0;
      run_period(1'b1, -1, 0);
      pay_tag = "R7";
      run_period(1'b0, 4, 16'hBEEF);
      run_period(1'b0, -1, 0);
      run_period(1'b0, -1, 0);
      pay_tag = "R3";

      // R9: length 0 acts as a one-cycle period
      nxt_b[0] = 0; nxt_b[1] = 0; nxt_b[2] = 1; nxt_b[3] = 1;
      nxt_per = 0;
      run_period(1'b1, -1, 0);
      st_tag = "R9";
      for (int r = 0; r < 20; r++) run_period(1'b0, -1, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule